// File: doc/BRIEF.md
# Urgency-Based Thread Switch Controller

This block decides when an in-order core that holds two hardware threads hands the pipeline from one thread to the other. Only one thread issues at a time (the foreground thread). The other waits in the background. Each thread has a 3-bit urgency level from 0 to 7. Events from the memory system, the interrupt logic and the thread itself raise or lower these levels, or force them to fixed values. Some events start a switch unconditionally. A last-level cache miss, or a refill for the waiting thread, starts one only when the waiting thread has become more urgent than the running one.

A switch starts by raising a flush request towards the pipeline. The request stays up for a fixed number of cycles. When it ends, the foreground thread ID flips and a one-cycle completion pulse is raised. An internal down-counter measures the time slice of the running thread. It is reloaded at every switch, and when it runs out it forces a switch. The cache, the pipeline and the interrupt controller lie outside the block and are seen only as single-cycle input pulses and output levels.

Top module: `thread_switch_ctl`

## Requirements
- R1: After reset both urgency levels are 5, thread 0 is in the foreground (`fgThread` = 0), and `flushActive` and `switchDone` are 0.
- R2: A miss pulse lowers the foreground thread's urgency by one. A miss at urgency 0 leaves it at 0.
- R3: A refill pulse raises the urgency of the thread named by `refillThread` (0 or 1) by one. A refill at urgency 5, 6 or 7 leaves the level unchanged.
- R4: If no switch starts for QUANTUM consecutive running cycles, a switch starts on the QUANTUM-th one. The thread being switched out gets urgency 7, which overrides any other update to it in that cycle.
- R5: An interrupt pulse for the background thread sets that thread's urgency to 6. This takes priority over a refill in the same cycle.
- R6: A miss starts a switch only if the background urgency is strictly greater than the foreground urgency after both have been updated in that cycle. A refill for the background thread starts a switch under the same comparison. A refill for the foreground thread never starts one.
- R7: A spin-lock/invalidation pulse, a software switch hint or a low-power-entry pulse each start a switch unconditionally while no flush is in progress.
- R8: When a switch starts, `flushActive` is high for exactly FLUSH_CYCLES cycles, starting in the next cycle. In the cycle after it falls, `switchDone` is high for one cycle and `fgThread` has flipped.
- R9: While a flush is in progress, every switch trigger is ignored: the flush is not lengthened and no second switch follows. Urgency updates still apply during the flush.
- R10: The time-slice counter is reloaded when each switch starts and holds during the flush. The QUANTUM running cycles that follow count from the `switchDone` cycle, which is the first of them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| missEv | input | 1 | Last-level cache miss by the foreground thread (pulse) |
| refillEv | input | 1 | Last-level cache refill (pulse) |
| refillThread | input | 1 | Thread that the refill belongs to |
| spinInvEv | input | 1 | Spin-lock or speculation-table invalidation (pulse) |
| swHintEv | input | 1 | Software-directed switch hint (pulse) |
| lowPowerEv | input | 1 | Foreground thread entered low-power execution (pulse) |
| bgIrqEv | input | 1 | Asynchronous interrupt for the background thread (pulse) |
| fgThread | output | 1 | ID of the thread that owns the pipeline |
| flushActive | output | 1 | Pipeline flush request, high for the whole flush |
| switchDone | output | 1 | One-cycle pulse when a switch completes |
| urgThread0 | output | 3 | Urgency level of thread 0 |
| urgThread1 | output | 3 | Urgency level of thread 1 |

## Verification
The assertions assume that every event input is a clean pulse synchronous to `clk` and that `refillThread` is valid whenever `refillEv` is high. They do not assume that events are mutually exclusive, because the block defines a fixed priority for coincident updates. The stimulus changes inputs only on the falling edge. A directed phase walks through each trigger, the saturation limits and the flush window. A random phase then mostly drives single events, with occasional interrupts on top of other events, so that the priority rules are also exercised.

// File: rtl/tsw_pkg.sv
package tsw_pkg;

  // Strobes from the switch sequencer to the urgency/quantum datapath
  typedef struct packed {
    logic beginSwitch;   // a switch starts this cycle
    logic quantumCause;  // the slice expiry is one cause of this switch
    logic endSwitch;     // the flush ends this cycle, flip foreground
    logic runPhase;      // no flush in progress
  } tswStrobes_t;

endpackage

// File: rtl/tsw_datapath.sv
module tsw_datapath
  import tsw_pkg::*;
#(
  parameter int URG_W       = 3,
  parameter int URG_INIT    = 5,
  parameter int REFILL_CAP  = 5,
  parameter int QUANTUM_URG = 7,
  parameter int IRQ_URG     = 6,
  parameter int QUANTUM     = 16
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  tswStrobes_t            strobes,
  input  logic                   missEv,
  input  logic                   refillEv,
  input  logic                   refillThread,
  input  logic                   bgIrqEv,
  output logic                   fgThread,
  output logic [1:0][URG_W-1:0]  urgLevel,
  output logic                   quantumExpired,
  output logic                   missSwitchOk,
  output logic                   refillSwitchOk
);

  localparam int QCNT_W = (QUANTUM > 2) ? $clog2(QUANTUM) : 1;
  localparam logic [QCNT_W-1:0] QRELOAD = QCNT_W'(QUANTUM - 1);
  localparam logic [URG_W-1:0] INIT_V = URG_W'(URG_INIT);
  localparam logic [URG_W-1:0] CAP_V  = URG_W'(REFILL_CAP);
  localparam logic [URG_W-1:0] QURG_V = URG_W'(QUANTUM_URG);
  localparam logic [URG_W-1:0] IRQ_V  = URG_W'(IRQ_URG);
  localparam logic [URG_W-1:0] ONE_V  = URG_W'(1);

  logic                  fgQ;
  logic [QCNT_W-1:0]     qCntQ;
  logic [1:0][URG_W-1:0] nextUrg;
  logic                  bgWins;

  // Per-thread urgency register with its update priority:
  // interrupt (background) > miss (foreground) > refill (named thread)
  for (genvar t = 0; t < 2; t++) begin : g_thread
    localparam logic THR = 1'(t);
    logic             isFg;
    logic [URG_W-1:0] urgQ;
    logic [URG_W-1:0] urgNxt;

    assign isFg = (fgQ == THR);

    always_comb begin
      urgNxt = urgQ;
      if (bgIrqEv && !isFg) begin
        urgNxt = IRQ_V;
      end else if (missEv && isFg) begin
        urgNxt = (urgQ == '0) ? '0 : urgQ - ONE_V;
      end else if (refillEv && (refillThread == THR) && (urgQ < CAP_V)) begin
        urgNxt = urgQ + ONE_V;
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        urgQ <= INIT_V;
      end else if (strobes.quantumCause && isFg) begin
        urgQ <= QURG_V;
      end else begin
        urgQ <= urgNxt;
      end
    end

    assign nextUrg[t]  = urgNxt;
    assign urgLevel[t] = urgQ;
  end

  assign bgWins         = nextUrg[~fgQ] > nextUrg[fgQ];
  assign missSwitchOk   = missEv && bgWins;
  assign refillSwitchOk = refillEv && (refillThread != fgQ) && bgWins;

  // Foreground ID flips only when the flush has drained
  always_ff @(posedge clk) begin
    if (!rstN) begin
      fgQ <= 1'b0;
    end else if (strobes.endSwitch) begin
      fgQ <= ~fgQ;
    end
  end

  // Time-slice down-counter: reload at switch start, hold during flush
  always_ff @(posedge clk) begin
    if (!rstN) begin
      qCntQ <= QRELOAD;
    end else if (strobes.beginSwitch) begin
      qCntQ <= QRELOAD;
    end else if (strobes.runPhase && (qCntQ != '0)) begin
      qCntQ <= qCntQ - 1'b1;
    end
  end

  assign quantumExpired = (qCntQ == '0);
  assign fgThread       = fgQ;

  // R2: a miss lowers the foreground level by one
  p_miss_dec_r2: assert property (@(posedge clk) disable iff (!rstN)
    (missEv && !strobes.quantumCause && urgLevel[fgThread] != '0)
    |=> urgLevel[$past(fgThread)] == $past(urgLevel[fgThread]) - ONE_V);

  // R2: a miss at level zero stays at zero
  p_miss_floor_r2: assert property (@(posedge clk) disable iff (!rstN)
    (missEv && !strobes.quantumCause && urgLevel[fgThread] == '0)
    |=> urgLevel[$past(fgThread)] == '0);

  // R3: refills do not lift a level that is already at or above the cap
  p_refill_cap_r3: assert property (@(posedge clk) disable iff (!rstN)
    (refillEv && urgLevel[refillThread] >= CAP_V
     && !(bgIrqEv && refillThread != fgThread)
     && !(missEv && refillThread == fgThread)
     && !(strobes.quantumCause && refillThread == fgThread))
    |=> urgLevel[$past(refillThread)] == $past(urgLevel[refillThread]));

  // R4: slice expiry leaves the outgoing thread at the top level
  p_quantum_top_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobes.quantumCause |=> urgLevel[$past(fgThread)] == QURG_V);

  // R5: an interrupt for the waiting thread forces its level
  p_irq_level_r5: assert property (@(posedge clk) disable iff (!rstN)
    bgIrqEv |=> urgLevel[$past(~fgThread)] == IRQ_V);

  // R10: the slice counter restarts from its full value at each switch
  p_quantum_reload_r10: assert property (@(posedge clk) disable iff (!rstN)
    strobes.beginSwitch |=> qCntQ == QRELOAD);

endmodule

// File: rtl/tsw_control.sv
module tsw_control
  import tsw_pkg::*;
#(
  parameter int FLUSH_CYCLES = 3
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        quantumExpired,
  input  logic        missSwitchOk,
  input  logic        refillSwitchOk,
  input  logic        spinInvEv,
  input  logic        swHintEv,
  input  logic        lowPowerEv,
  output tswStrobes_t strobes,
  output logic        flushActive,
  output logic        switchDone
);

  localparam int FCNT_W = (FLUSH_CYCLES > 2) ? $clog2(FLUSH_CYCLES) : 1;
  localparam logic [FCNT_W-1:0] FLOAD = FCNT_W'(FLUSH_CYCLES - 1);

  typedef enum logic { ST_RUN, ST_FLUSH } tswState_e;

  tswState_e         stateQ;
  logic [FCNT_W-1:0] flushCntQ;
  logic              doneQ;
  logic              running;
  logic              trigger;

  assign running = (stateQ == ST_RUN);
  assign trigger = running && (quantumExpired || spinInvEv || swHintEv ||
                               lowPowerEv || missSwitchOk || refillSwitchOk);

  always_comb begin
    strobes.runPhase     = running;
    strobes.beginSwitch  = trigger;
    strobes.quantumCause = running && quantumExpired;
    strobes.endSwitch    = (stateQ == ST_FLUSH) && (flushCntQ == '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ    <= ST_RUN;
      flushCntQ <= '0;
      doneQ     <= 1'b0;
    end else begin
      doneQ <= strobes.endSwitch;
      case (stateQ)
        ST_RUN: begin
          if (trigger) begin
            stateQ    <= ST_FLUSH;
            flushCntQ <= FLOAD;
          end
        end
        ST_FLUSH: begin
          if (flushCntQ == '0) begin
            stateQ <= ST_RUN;
          end else begin
            flushCntQ <= flushCntQ - 1'b1;
          end
        end
        default: stateQ <= ST_RUN;
      endcase
    end
  end

  assign flushActive = (stateQ == ST_FLUSH);
  assign switchDone  = doneQ;

  // Length of the current flush window, counted independently
  int flushSeen;
  always_ff @(posedge clk) begin
    if (!rstN || !flushActive) flushSeen <= 0;
    else                       flushSeen <= flushSeen + 1;
  end

  // R8: the flush request lasts exactly FLUSH_CYCLES cycles
  p_flush_len_r8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(flushActive) |-> flushSeen == FLUSH_CYCLES);

  // R8: completion is a single-cycle pulse that follows a flush
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    switchDone |=> !switchDone);
  p_done_after_flush_r8: assert property (@(posedge clk) disable iff (!rstN)
    switchDone |-> $past(flushActive) && !flushActive);

  // R9: no new switch may begin while flushing
  p_no_retrigger_r9: assert property (@(posedge clk) disable iff (!rstN)
    flushActive |-> !strobes.beginSwitch);

endmodule

// File: rtl/thread_switch_ctl.sv
module thread_switch_ctl
  import tsw_pkg::*;
#(
  parameter int URG_W        = 3,
  parameter int URG_INIT     = 5,
  parameter int REFILL_CAP   = 5,
  parameter int QUANTUM_URG  = 7,
  parameter int IRQ_URG      = 6,
  parameter int QUANTUM      = 16,
  parameter int FLUSH_CYCLES = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             missEv,
  input  logic             refillEv,
  input  logic             refillThread,
  input  logic             spinInvEv,
  input  logic             swHintEv,
  input  logic             lowPowerEv,
  input  logic             bgIrqEv,
  output logic             fgThread,
  output logic             flushActive,
  output logic             switchDone,
  output logic [URG_W-1:0] urgThread0,
  output logic [URG_W-1:0] urgThread1
);

  tswStrobes_t           strobes;
  logic [1:0][URG_W-1:0] urgLevel;
  logic                  quantumExpired;
  logic                  missSwitchOk;
  logic                  refillSwitchOk;

  tsw_datapath #(
    .URG_W(URG_W), .URG_INIT(URG_INIT), .REFILL_CAP(REFILL_CAP),
    .QUANTUM_URG(QUANTUM_URG), .IRQ_URG(IRQ_URG), .QUANTUM(QUANTUM)
  ) u_datapath (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .missEv(missEv), .refillEv(refillEv), .refillThread(refillThread),
    .bgIrqEv(bgIrqEv), .fgThread(fgThread), .urgLevel(urgLevel),
    .quantumExpired(quantumExpired), .missSwitchOk(missSwitchOk),
    .refillSwitchOk(refillSwitchOk)
  );

  tsw_control #(
    .FLUSH_CYCLES(FLUSH_CYCLES)
  ) u_control (
    .clk(clk), .rstN(rstN), .quantumExpired(quantumExpired),
    .missSwitchOk(missSwitchOk), .refillSwitchOk(refillSwitchOk),
    .spinInvEv(spinInvEv), .swHintEv(swHintEv), .lowPowerEv(lowPowerEv),
    .strobes(strobes), .flushActive(flushActive), .switchDone(switchDone)
  );

  assign urgThread0 = urgLevel[0];
  assign urgThread1 = urgLevel[1];

  // R8: every completed switch hands the pipe to the other thread
  p_fg_flip_r8: assert property (@(posedge clk) disable iff (!rstN)
    switchDone |-> fgThread != $past(fgThread));

endmodule

// File: tb/thread_switch_ctl_tb.sv
module thread_switch_ctl_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int Q = 8;
  localparam int F = 3;

  localparam int EV_MISS = 1, EV_REF = 2, EV_SPIN = 4, EV_SW = 8, EV_LP = 16, EV_IRQ = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic missEv = 0, refillEv = 0, refillThread = 0, spinInvEv = 0;
  logic swHintEv = 0, lowPowerEv = 0, bgIrqEv = 0;
  logic fgThread, flushActive, switchDone;
  logic [2:0] urgThread0, urgThread1;

  always #(CLK_PERIOD / 2) clk = ~clk;

  thread_switch_ctl #(.QUANTUM(Q), .FLUSH_CYCLES(F)) dut_i (
    .clk(clk), .rstN(rstN), .missEv(missEv), .refillEv(refillEv),
    .refillThread(refillThread), .spinInvEv(spinInvEv), .swHintEv(swHintEv),
    .lowPowerEv(lowPowerEv), .bgIrqEv(bgIrqEv), .fgThread(fgThread),
    .flushActive(flushActive), .switchDone(switchDone),
    .urgThread0(urgThread0), .urgThread1(urgThread1)
  );

  int  nChecks = 0;
  int  nFails  = 0;
  bit  finished = 0;

  // Behavioural reference state
  int mUrg[2];
  int mFg, mQ, mFlushLeft;
  bit mFlushing, mDone;

  task automatic chk(string tag, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic modelInit();
    mUrg[0] = 5; mUrg[1] = 5; mFg = 0; mQ = Q - 1;
    mFlushLeft = 0; mFlushing = 0; mDone = 0;
  endtask

  task automatic modelStep();
    int n[2];
    int bg;
    bit qexp, trig;
    bg = 1 - mFg;
    for (int t = 0; t < 2; t++) begin
      n[t] = mUrg[t];
      if (bgIrqEv && t == bg)                  n[t] = 6;
      else if (missEv && t == mFg)             n[t] = (mUrg[t] > 0) ? mUrg[t] - 1 : 0;
      else if (refillEv && t == int'(refillThread) && mUrg[t] < 5) n[t] = mUrg[t] + 1;
    end
    mDone = 0;
    if (!mFlushing) begin
      qexp = (mQ == 0);
      trig = qexp || spinInvEv || swHintEv || lowPowerEv
          || (missEv && n[bg] > n[mFg])
          || (refillEv && int'(refillThread) == bg && n[bg] > n[mFg]);
      if (trig) begin
        if (qexp) n[mFg] = 7;
        mFlushing = 1; mFlushLeft = F - 1; mQ = Q - 1;
      end else if (mQ > 0) begin
        mQ--;
      end
    end else begin
      if (mFlushLeft == 0) begin
        mFlushing = 0; mFg = bg; mDone = 1;
      end else begin
        mFlushLeft--;
      end
    end
    mUrg[0] = n[0]; mUrg[1] = n[1];
  endtask

  task automatic compareAll();
    chk("R2/R3/R4/R5 urgency thread0", int'(urgThread0), mUrg[0]);
    chk("R2/R3/R4/R5 urgency thread1", int'(urgThread1), mUrg[1]);
    chk("R8 fgThread", int'(fgThread), mFg);
    chk("R6/R7/R8/R9/R10 flushActive", int'(flushActive), int'(mFlushing));
    chk("R8 switchDone", int'(switchDone), int'(mDone));
  endtask

  // One clock: drive at the falling edge, model at the rising edge, compare at the next falling edge
  task automatic cyc(int ev, int rth = 0);
    missEv = ev[0]; refillEv = ev[1]; spinInvEv = ev[2];
    swHintEv = ev[3]; lowPowerEv = ev[4]; bgIrqEv = ev[5];
    refillThread = rth[0];
    @(posedge clk);
    modelStep();
    @(negedge clk);
    compareAll();
    missEv = 0; refillEv = 0; spinInvEv = 0; swHintEv = 0; lowPowerEv = 0; bgIrqEv = 0;
  endtask

  task automatic waitDone(string tag);
    int g = 0;
    while (!switchDone && g < 20) begin
      cyc(0);
      g++;
    end
    chk(tag, int'(switchDone), 1);
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL R8 watchdog expired actual=%0d expected=%0d", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    int flushCount;
    modelInit();
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 reset urgency thread0", int'(urgThread0), 5);
    chk("R1 reset urgency thread1", int'(urgThread1), 5);
    chk("R1 reset fgThread", int'(fgThread), 0);
    chk("R1 reset flushActive", int'(flushActive), 0);
    chk("R1 reset switchDone", int'(switchDone), 0);
    rstN = 1'b1;

    // R2 + R6: miss 5->4, background 5 > 4 starts a switch
    cyc(EV_MISS);
    chk("R2 miss decrement", int'(urgThread0), 4);
    chk("R6 miss switch when background wins", int'(flushActive), 1);
    flushCount = 1;
    // R9: hint during flush ignored
    cyc(EV_SW);
    flushCount += int'(flushActive);
    cyc(0);
    flushCount += int'(flushActive);
    cyc(0);
    chk("R8 flush length", flushCount, F);
    chk("R8 done pulse", int'(switchDone), 1);
    chk("R8 foreground flipped", int'(fgThread), 1);
    cyc(0);
    chk("R9 hint during flush ignored", int'(flushActive), 0);
    chk("R8 done lasts one cycle", int'(switchDone), 0);

    // R6: miss 5->4 on thread1, background 4 not greater
    cyc(EV_MISS);
    chk("R2 miss decrement thread1", int'(urgThread1), 4);
    chk("R6 no switch on equal urgency", int'(flushActive), 0);
    // R5
    cyc(EV_IRQ);
    chk("R5 interrupt level", int'(urgThread0), 6);
    chk("R5 interrupt is no trigger", int'(flushActive), 0);
    // R3
    cyc(EV_REF, 1);
    chk("R3 refill increment", int'(urgThread1), 5);
    chk("R6 foreground refill no switch", int'(flushActive), 0);
    cyc(EV_REF, 1);
    chk("R3 refill cap", int'(urgThread1), 5);
    cyc(0);
    cyc(0);
    chk("R10 no expiry before slice ends", int'(flushActive), 0);
    cyc(0);
    chk("R4 slice expiry starts switch", int'(flushActive), 1);
    chk("R4 outgoing level 7", int'(urgThread1), 7);
    waitDone("R8 switch completes after expiry");
    chk("R8 back to thread0", int'(fgThread), 0);

    // R7 unconditional triggers
    cyc(EV_LP);
    chk("R7 low-power switch", int'(flushActive), 1);
    waitDone("R8 switch completes after low-power");
    cyc(EV_SPIN);
    chk("R7 spin/invalidation switch", int'(flushActive), 1);
    waitDone("R8 switch completes after spin");

    // R6: thread0 6->5 vs 7
    cyc(EV_MISS);
    chk("R6 miss switch to more urgent", int'(flushActive), 1);
    waitDone("R8 switch completes after miss");
    cyc(EV_REF, 0);
    chk("R3 refill at cap of background", int'(urgThread0), 5);
    chk("R6 background refill not winning", int'(flushActive), 0);

    // Drive both threads to zero with misses
    for (int k = 0; k < 80 && !(urgThread0 == 0 && urgThread1 == 0); k++) begin
      cyc(EV_MISS);
      while (flushActive) cyc(0);
    end
    cyc(EV_MISS);
    chk("R2 miss floor", fgThread ? int'(urgThread1) : int'(urgThread0), 0);
    chk("R6 no switch at equal zero", int'(flushActive), 0);
    cyc(EV_REF, fgThread ? 0 : 1);
    chk("R6 background refill switch", int'(flushActive), 1);
    waitDone("R8 switch completes after refill");

    // Random phase, compared every cycle against the model
    for (int i = 0; i < 3000; i++) begin
      int r, ev;
      r = int'($urandom % 100);
      ev = 0;
      if (r < 30)      ev = EV_MISS;
      else if (r < 50) ev = EV_REF;
      else if (r < 55) ev = EV_IRQ;
      else if (r < 58) ev = EV_SW;
      else if (r < 60) ev = EV_SPIN;
      else if (r < 61) ev = EV_LP;
      if ($urandom % 10 == 0) ev = ev | EV_IRQ;
      cyc(ev, int'($urandom % 2));
    end

    finished = 1;
    summary();
    $finish;
  end

endmodule